// File: doc/BRIEF.md
# Biphase-Mark Stereo Audio Transmitter

This block turns a stream of 16-bit stereo sample pairs into a single biphase-mark coded serial line of the kind used for consumer digital audio links. Each sample goes out in a 32-slot subframe. A subframe holds a synchronising preamble, four auxiliary slots, a 20-slot audio field with the sample justified to its top, and validity, user, channel-status and parity slots. Subframes alternate left and right, and 384 of them form one block. Over a block, the channel-status slot spells out a fixed 192-bit word. That word carries the source's control bits, a fixed category code and a selectable clock-accuracy code.

The line is paced by a half-bit-cell enable at 128 times the sample rate, which is 5.6448 MHz for 44.1 kHz audio. The enable may arrive on any subset of clock cycles, and the line moves only on enabled edges. The block latches a whole sample pair and its side information at the enabled edge that starts each left subframe. It marks that capture with a one-cycle strobe so the source knows when to present the next pair. A force-low input holds the line at logic 0 without stopping the encoder.

Top module: `biphase_audio_tx`

## Requirements
- R1: While rst_n is low, line_out and pair_take are 0; the first subframe after reset is a left subframe that starts a block.
- R2: The encoded line changes only at a clock edge where half_en is 1; each slot occupies two consecutive enabled half-cells, and a subframe occupies 64.
- R3: The 16-bit two's-complement sample occupies slots 12 (LSB) to 27 (MSB); slots 8 to 11 are always 0.
- R4: With flag_en at 0, slots 4 to 7 are 0. With flag_en at 1, the left subframe carries flag_bits[3:0] and the right subframe carries flag_bits[7:4], with the lowest flag bit in slot 4.
- R5: Slot 28 (validity) equals the error flag of that subframe's channel: left_bad for left, right_bad for right.
- R6: A block holds 384 subframes alternating left and right. Pair index 0 of a block uses the block-start preamble (half-cells 11101000), other left subframes use 11100010, and right subframes use 11100100, with the first half-cell listed first. These patterns apply when the line is low just before the preamble and are inverted when it is high.
- R7: Slot 29 carries user_bit as sampled at the enabled edge that starts the subframe.
- R8: Slot 30 carries bit k of a 192-bit channel-status word, where k is the pair index within the block and is the same for both subframes of a pair. Bit k is ctl_bits[k] for k from 0 to 3, bit 8 is 1, bit 28 is clk_acc[1], bit 29 is clk_acc[0], and every other bit is 0.
- R9: Slot 31 makes the count of ones in slots 4 to 31 even, so the line ends every subframe at the level it had just before that subframe's preamble.
- R10: Every data slot begins with a line transition, and a slot holding 1 also has a transition between its two half-cells.
- R11: While force_low is 1, line_out is 0. The encoder keeps running, and on release line_out follows the encoder's current level.
- R12: left_smp, right_smp, both error flags, flag_en, flag_bits, ctl_bits and clk_acc are captured at the enabled edge that starts a left subframe and serve both subframes of that pair; pair_take is 1 for exactly the following clock cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| half_en | input | 1 | Half-bit-cell enable, 128 times the sample rate |
| left_smp | input | 16 | Left sample, two's complement |
| right_smp | input | 16 | Right sample, two's complement |
| left_bad | input | 1 | Left sample had an uncorrectable error |
| right_bad | input | 1 | Right sample had an uncorrectable error |
| flag_en | input | 1 | Put correction flags in the auxiliary slots |
| flag_bits | input | 8 | Correction and concealment flags for the pair |
| user_bit | input | 1 | User-data bit for the next subframe |
| ctl_bits | input | 4 | Control bits for channel-status bits 0 to 3 |
| clk_acc | input | 2 | Clock-accuracy code for channel-status bits 28 and 29 |
| force_low | input | 1 | Hold the output line low |
| line_out | output | 1 | Biphase-mark coded output |
| pair_take | output | 1 | One-cycle strobe after a sample pair is captured |

## Verification
The hardest conditions to reach from the ports are the block wrap and the few channel-status positions carrying the clock-accuracy code and block-start preamble, which occur only once per 24,576 enabled half-cells. The stimulus therefore runs past two full block boundaries. It randomises every input on every cycle, so each captured value comes from whatever was present at that exact edge. It varies the enable pattern between sparse, dense and fully paused stretches, and it overlaps force-low windows with running encoding. This shows that both capture timing and line continuity hold across those changes.

// File: rtl/bmc_tx_pkg.sv
package bmc_tx_pkg;
  localparam int SLOTS      = 32;
  localparam int HALVES     = 2 * SLOTS;
  localparam int POS_W      = $clog2(HALVES);
  localparam int PRE_HALVES = 8;
  localparam int SMP_W      = 16;
  localparam int AUX_W      = 4;
  localparam int FLAG_W     = 2 * AUX_W;
  localparam int CTL_W      = 4;
  localparam int ACC_W      = 2;
  localparam int AUX_LO     = 4;
  localparam int SMP_LO     = 12;
  localparam int VAL_SLOT   = 28;
  localparam int USR_SLOT   = 29;
  localparam int CS_SLOT    = 30;
  localparam int PAR_SLOT   = 31;
  localparam int CS_CAT_BIT = 8;
  localparam int CS_ACC_BIT = 28;

  typedef enum logic [1:0] {PRE_BLK, PRE_LEFT, PRE_RIGHT} pre_kind_e;
  typedef logic [SLOTS-1:0] slot_word_t;

  // Half-cell shape of a preamble, first half-cell in the MSB, line low before.
  function automatic logic [PRE_HALVES-1:0] pre_shape(pre_kind_e kind);
    case (kind)
      PRE_BLK:   return 8'b1110_1000;
      PRE_LEFT:  return 8'b1110_0010;
      PRE_RIGHT: return 8'b1110_0100;
      default:   return '0;
    endcase
  endfunction

  // Channel-status bit for pair index idx within the block.
  function automatic logic cs_bit(int unsigned idx, logic [CTL_W-1:0] ctl,
                                  logic [ACC_W-1:0] acc);
    if (idx < CTL_W)            return ctl[idx[1:0]];
    if (idx == CS_CAT_BIT)      return 1'b1;
    if (idx == CS_ACC_BIT)      return acc[1];
    if (idx == CS_ACC_BIT + 1)  return acc[0];
    return 1'b0;
  endfunction

  // Assemble the 32 slots of a subframe, slots 0..3 left empty, even parity last.
  function automatic slot_word_t pack_slots(logic [AUX_W-1:0] aux,
                                            logic [SMP_W-1:0] smp,
                                            logic bad, logic usr, logic cs);
    slot_word_t w;
    w = '0;
    w[AUX_LO +: AUX_W] = aux;
    w[SMP_LO +: SMP_W] = smp;
    w[VAL_SLOT]        = bad;
    w[USR_SLOT]        = usr;
    w[CS_SLOT]         = cs;
    w[PAR_SLOT]        = ^w[CS_SLOT:AUX_LO];
    return w;
  endfunction
endpackage

// File: rtl/bmc_frame_ctr.sv
module bmc_frame_ctr
  import bmc_tx_pkg::*;
#(
  parameter int BLOCK = 384,
  parameter int SUB_W = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             half_en,
  output logic [POS_W-1:0] pos,
  output logic [SUB_W-1:0] sub,
  output logic             sf_start
);
  localparam logic [POS_W-1:0] POS_LAST = POS_W'(HALVES - 1);
  localparam logic [SUB_W-1:0] SUB_LAST = SUB_W'(BLOCK - 1);

  assign sf_start = half_en && (pos == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pos <= '0;
      sub <= '0;
    end else if (half_en) begin
      pos <= pos + 1'b1;
      if (pos == POS_LAST)
        sub <= (sub == SUB_LAST) ? '0 : sub + 1'b1;
    end
  end
endmodule

// File: rtl/bmc_word_gen.sv
module bmc_word_gen
  import bmc_tx_pkg::*;
#(
  parameter int SUB_W = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sf_start,
  input  logic [SUB_W-1:0]  sub,
  input  logic [SMP_W-1:0]  left_smp,
  input  logic [SMP_W-1:0]  right_smp,
  input  logic              left_bad,
  input  logic              right_bad,
  input  logic              flag_en,
  input  logic [FLAG_W-1:0] flag_bits,
  input  logic              user_bit,
  input  logic [CTL_W-1:0]  ctl_bits,
  input  logic [ACC_W-1:0]  clk_acc,
  output slot_word_t        word,
  output pre_kind_e         pre_kind,
  output logic              pair_take
);
  logic              is_left;
  int unsigned       pair_idx;
  logic [SMP_W-1:0]  hold_smp;
  logic              hold_bad;
  logic              hold_fen;
  logic [AUX_W-1:0]  hold_aux;
  logic [CTL_W-1:0]  hold_ctl;
  logic [ACC_W-1:0]  hold_acc;
  slot_word_t        word_d;

  assign is_left  = ~sub[0];
  assign pair_idx = 32'(sub[SUB_W-1:1]);

  always_comb begin
    if (!is_left)             pre_kind = PRE_RIGHT;
    else if (pair_idx == 0)   pre_kind = PRE_BLK;
    else                      pre_kind = PRE_LEFT;
  end

  always_comb begin
    if (is_left)
      word_d = pack_slots(flag_en ? flag_bits[AUX_W-1:0] : '0, left_smp,
                          left_bad, user_bit, cs_bit(pair_idx, ctl_bits, clk_acc));
    else
      word_d = pack_slots(hold_fen ? hold_aux : '0, hold_smp,
                          hold_bad, user_bit, cs_bit(pair_idx, hold_ctl, hold_acc));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      word      <= '0;
      pair_take <= 1'b0;
      hold_smp  <= '0;
      hold_bad  <= 1'b0;
      hold_fen  <= 1'b0;
      hold_aux  <= '0;
      hold_ctl  <= '0;
      hold_acc  <= '0;
    end else begin
      pair_take <= sf_start && is_left;
      if (sf_start) begin
        word <= word_d;
        if (is_left) begin
          hold_smp <= right_smp;
          hold_bad <= right_bad;
          hold_fen <= flag_en;
          hold_aux <= flag_bits[FLAG_W-1:AUX_W];
          hold_ctl <= ctl_bits;
          hold_acc <= clk_acc;
        end
      end
    end
  end
endmodule

// File: rtl/bmc_line_enc.sv
module bmc_line_enc
  import bmc_tx_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             half_en,
  input  logic [POS_W-1:0] pos,
  input  pre_kind_e        pre_kind,
  input  slot_word_t       word,
  output logic             line_lvl
);
  logic                  base_q;
  logic                  line_d;
  logic [PRE_HALVES-1:0] shape;

  assign shape = pre_shape(pre_kind);

  always_comb begin
    if (pos < POS_W'(PRE_HALVES))
      line_d = shape[3'd7 - pos[2:0]] ^ ((pos == '0) ? line_lvl : base_q);
    else if (!pos[0])
      line_d = ~line_lvl;
    else
      line_d = line_lvl ^ word[pos[POS_W-1:1]];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      line_lvl <= 1'b0;
      base_q   <= 1'b0;
    end else if (half_en) begin
      line_lvl <= line_d;
      if (pos == '0) base_q <= line_lvl;
    end
  end
endmodule

// File: rtl/biphase_audio_tx.sv
module biphase_audio_tx
  import bmc_tx_pkg::*;
#(
  parameter int BLOCK_SUBFRAMES = 384
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        half_en,
  input  logic [15:0] left_smp,
  input  logic [15:0] right_smp,
  input  logic        left_bad,
  input  logic        right_bad,
  input  logic        flag_en,
  input  logic [7:0]  flag_bits,
  input  logic        user_bit,
  input  logic [3:0]  ctl_bits,
  input  logic [1:0]  clk_acc,
  input  logic        force_low,
  output logic        line_out,
  output logic        pair_take
);
  localparam int SUB_W = $clog2(BLOCK_SUBFRAMES);

  logic [POS_W-1:0] pos;
  logic [SUB_W-1:0] sub;
  logic             sf_start;
  slot_word_t       word;
  pre_kind_e        pre_kind;
  logic             line_lvl;

  bmc_frame_ctr #(.BLOCK(BLOCK_SUBFRAMES), .SUB_W(SUB_W)) u_ctr (
    .clk(clk), .rst_n(rst_n), .half_en(half_en),
    .pos(pos), .sub(sub), .sf_start(sf_start)
  );

  bmc_word_gen #(.SUB_W(SUB_W)) u_word (
    .clk(clk), .rst_n(rst_n), .sf_start(sf_start), .sub(sub),
    .left_smp(left_smp), .right_smp(right_smp),
    .left_bad(left_bad), .right_bad(right_bad),
    .flag_en(flag_en), .flag_bits(flag_bits), .user_bit(user_bit),
    .ctl_bits(ctl_bits), .clk_acc(clk_acc),
    .word(word), .pre_kind(pre_kind), .pair_take(pair_take)
  );

  bmc_line_enc u_enc (
    .clk(clk), .rst_n(rst_n), .half_en(half_en), .pos(pos),
    .pre_kind(pre_kind), .word(word), .line_lvl(line_lvl)
  );

  assign line_out = line_lvl & ~force_low;
endmodule

// File: rtl/bmc_tx_checker.sv
module bmc_tx_checker
  import bmc_tx_pkg::*;
#(
  parameter int BLOCK = 384,
  parameter int SUB_W = 9
) (
  input logic             clk,
  input logic             rst_n,
  input logic             half_en,
  input logic [POS_W-1:0] pos,
  input logic [SUB_W-1:0] sub,
  input logic             sf_start,
  input logic             line_q,
  input logic             pair_take
);
  logic lvl_mark;
  logic seen;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lvl_mark <= 1'b0;
      seen     <= 1'b0;
    end else if (sf_start) begin
      lvl_mark <= line_q;
      seen     <= 1'b1;
    end
  end

  AST_SUBFRAME_LEVEL_RETURN: assert property (@(posedge clk) disable iff (!rst_n)
    (sf_start && seen) |-> (line_q == lvl_mark)); // R9

  AST_SLOT_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
    (half_en && pos >= POS_W'(PRE_HALVES) && !pos[0]) |=> (line_q != $past(line_q))); // R10

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !half_en |=> $stable(line_q)); // R2

  AST_BLOCK_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (half_en && pos == POS_W'(HALVES - 1) && sub == SUB_W'(BLOCK - 1)) |=> (sub == '0)); // R6

  AST_TAKE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    pair_take |=> !pair_take); // R12

  AST_TAKE_AT_LEFT: assert property (@(posedge clk) disable iff (!rst_n)
    pair_take |-> ($past(sf_start) && !sub[0])); // R12
endmodule

bind biphase_audio_tx bmc_tx_checker #(.BLOCK(BLOCK_SUBFRAMES), .SUB_W(SUB_W)) u_bmc_chk (
  .clk(clk), .rst_n(rst_n), .half_en(half_en), .pos(pos), .sub(sub),
  .sf_start(sf_start), .line_q(line_lvl), .pair_take(pair_take)
);

// File: tb/test_biphase_audio_tx.sv
`timescale 1ns/1ps
module test_biphase_audio_tx;
  localparam int NCYC  = 90000;
  localparam int BLOCK = 384;

  logic clk = 1'b0;
  logic rst_n;
  logic half_en, left_bad, right_bad, flag_en, user_bit, force_low;
  logic [15:0] left_smp, right_smp;
  logic [7:0]  flag_bits;
  logic [3:0]  ctl_bits;
  logic [1:0]  clk_acc;
  logic line_out, pair_take;

  always #2 clk = ~clk;

  biphase_audio_tx i_biphase_audio_tx (
    .clk(clk), .rst_n(rst_n), .half_en(half_en),
    .left_smp(left_smp), .right_smp(right_smp),
    .left_bad(left_bad), .right_bad(right_bad),
    .flag_en(flag_en), .flag_bits(flag_bits), .user_bit(user_bit),
    .ctl_bits(ctl_bits), .clk_acc(clk_acc), .force_low(force_low),
    .line_out(line_out), .pair_take(pair_take)
  );

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  // reference model state
  bit    exp_q[$];
  string tag_q[$];
  bit    m_line = 0;
  string m_tag  = "R1";
  int    m_pos = 0, m_sub = 0;
  bit    take_pend = 0;
  bit    last_en = 0;
  bit [15:0] c_r; bit c_rbad, c_fen; bit [3:0] c_fhi, c_ctl; bit [1:0] c_acc;

  function automatic string slot_tag(int s);
    if (s < 8)   return "R4";
    if (s < 28)  return "R3";
    if (s == 28) return "R5";
    if (s == 29) return "R7";
    if (s == 30) return "R8";
    return "R9";
  endfunction

  function automatic bit status_bit(int k, bit [3:0] ctl, bit [1:0] acc);
    case (k)
      0, 1, 2, 3: return ctl[k];
      8:          return 1'b1;
      28:         return acc[1];
      29:         return acc[0];
      default:    return 1'b0;
    endcase
  endfunction

  function automatic bit [15:0] pick_smp();
    case ($urandom % 6)
      0: return 16'h0000;
      1: return 16'hFFFF;
      2: return 16'h8000;
      3: return 16'h7FFF;
      4: return 16'h0001;
      default: return 16'($urandom);
    endcase
  endfunction

  task automatic check(bit ok, string req, string what, int act, int expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d at %0t", req, what, act, expv, $time);
    end
  endtask

  // build the 64 expected half-cell levels of the subframe that starts now
  task automatic build_subframe();
    bit sl[32];
    bit [7:0] shape;
    bit lvl;
    int ones;
    bit left = (m_sub % 2 == 0);
    int k = m_sub / 2;
    foreach (sl[i]) sl[i] = 0;
    if (left) begin
      for (int i = 0; i < 4; i++)  sl[4 + i]  = flag_en ? flag_bits[i] : 1'b0;
      for (int i = 0; i < 16; i++) sl[12 + i] = left_smp[i];
      sl[28] = left_bad;
      sl[30] = status_bit(k, ctl_bits, clk_acc);
      c_r = right_smp; c_rbad = right_bad; c_fen = flag_en;
      c_fhi = flag_bits[7:4]; c_ctl = ctl_bits; c_acc = clk_acc;
      take_pend = 1;
      shape = (k == 0) ? 8'b1110_1000 : 8'b1110_0010;  // R6
    end else begin
      for (int i = 0; i < 4; i++)  sl[4 + i]  = c_fen ? c_fhi[i] : 1'b0;
      for (int i = 0; i < 16; i++) sl[12 + i] = c_r[i];
      sl[28] = c_rbad;
      sl[30] = status_bit(k, c_ctl, c_acc);
      shape = 8'b1110_0100;
    end
    sl[29] = user_bit;
    ones = 0;
    for (int s = 4; s < 31; s++) ones += sl[s];
    sl[31] = ones[0];
    for (int h = 0; h < 8; h++) begin
      exp_q.push_back(shape[7 - h] ^ m_line);
      tag_q.push_back("R6");
    end
    lvl = m_line;
    for (int s = 4; s < 32; s++) begin
      lvl = !lvl;
      exp_q.push_back(lvl); tag_q.push_back("R10");
      if (sl[s]) lvl = !lvl;
      exp_q.push_back(lvl); tag_q.push_back(slot_tag(s));
    end
  endtask

  task automatic model_step();
    if (m_pos == 0) build_subframe();
    m_line = exp_q.pop_front();
    m_tag  = tag_q.pop_front();
    m_pos++;
    if (m_pos == 64) begin
      m_pos = 0;
      m_sub = (m_sub + 1) % BLOCK;
    end
  endtask

  initial begin
    #(4 * 150000);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    string req;
    bit    exp_line;
    rst_n = 0; half_en = 0; left_smp = 0; right_smp = 0; left_bad = 0;
    right_bad = 0; flag_en = 0; flag_bits = 0; user_bit = 0; ctl_bits = 0;
    clk_acc = 0; force_low = 0;
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      half_en = 1;  // ignored under reset
      check(line_out == 1'b0, "R1", "line_out in reset", line_out, 0);
      check(pair_take == 1'b0, "R1", "pair_take in reset", pair_take, 0);
    end
    @(negedge clk);
    half_en = 0;
    rst_n = 1;
    for (int cyc = 0; cyc < NCYC; cyc++) begin
      @(negedge clk);
      // compare against model state after the last edge
      exp_line = force_low ? 1'b0 : m_line;
      req = force_low ? "R11" : (last_en ? m_tag : "R2");
      check(line_out == exp_line, req, "line_out", line_out, exp_line);
      check(pair_take == take_pend, "R12", "pair_take", pair_take, take_pend);
      take_pend = 0;
      // drive stimulus for the next edge
      if (cyc >= 20000 && cyc < 20300)      half_en = 0;            // R2 pause
      else if (cyc >= 50000 && cyc < 52000) half_en = 1;            // back-to-back
      else                                  half_en = (cyc % 3 != 0);
      force_low = (cyc >= 40000 && cyc < 41000) || (cyc >= 70000 && cyc < 70050); // R11
      left_smp  = pick_smp();
      right_smp = pick_smp();
      left_bad  = ($urandom % 4 == 0);
      right_bad = ($urandom % 4 == 1);
      flag_en   = ($urandom % 2 == 0);
      flag_bits = 8'($urandom);
      user_bit  = 1'($urandom);
      ctl_bits  = 4'($urandom);
      clk_acc   = 2'($urandom);
      if (half_en) model_step();
      last_en = half_en;
    end
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule